// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock

This block resolves read-after-write data hazards for an in-order integer pipeline with five stages: fetch, decode with register read, execute, memory and write-back. Each cycle the decode stage presents the register numbers of the instruction it holds: its two sources, its destination, whether it writes a register and whether it is a load. The block keeps its own copy of these hazard-relevant fields as they move into the execute, memory and write-back pipeline registers. Using that copy, it tells the execute-stage operand multiplexers whether each operand comes from the register file or from a newer result that has not yet been written back.

A load produces its data only at the end of the memory stage, so forwarding cannot cover a consumer that directly follows it. For that case the block raises a front-end hold that freezes the program counter and the fetch/decode register. It also raises a bubble request that zeroes the control bits entering the execute stage, for exactly one cycle. The register file is assumed to write in the first half of a cycle and read in the second, so a result in write-back needs no extra path.

Top module: `hz_bypass_interlock`

## Requirements
- R1: After a synchronous reset with an idle decode stage (all inputs zero), both operand selects read 2'b00 and both `front_hold` and `ctrl_bubble` are low.
- R2: An operand whose source register equals the destination of a writing instruction one stage ahead (memory stage) selects code 2'b10.
- R3: An operand whose source register equals the destination of a writing instruction in the write-back stage, with no match one stage ahead, selects code 2'b01.
- R4: When the memory-stage and write-back-stage instructions both write the operand's source register, the select is 2'b10.
- R5: Register number 0 used as a destination never produces a forward select or a stall.
- R6: A producer whose write-enable is 0 never produces a forward select or a stall, even if it is flagged as a load.
- R7: A producer three or more instructions ahead of its consumer gives select 2'b00 (register file).
- R8: When the execute-stage instruction is a writing load and its destination matches either source of the decode instruction, `front_hold` and `ctrl_bubble` are both high in that cycle. In the next cycle, with the same decode instruction still presented, both are low. The inserted bubble writes no register.
- R9: After a load-use stall, the dependent instruction in execute takes the load result with select 2'b01 on the matching operand.
- R10: A matching producer in execute that is not a load, or a load whose destination matches neither decode source, causes no stall. A load two instructions ahead of its consumer is forwarded with code 2'b01.
- R11: Operand A follows the first source (rs) and operand B the second source (rt), each selected independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_rs | input | AW | First source register of the decode instruction |
| dec_rt | input | AW | Second source register of the decode instruction |
| dec_rd | input | AW | Destination register of the decode instruction |
| dec_wr | input | 1 | Decode instruction writes a register |
| dec_ld | input | 1 | Decode instruction is a load |
| fwd_a_sel | output | 2 | Operand A source: 00 register file, 10 memory stage, 01 write-back stage |
| fwd_b_sel | output | 2 | Operand B source, same coding |
| front_hold | output | 1 | Hold program counter and fetch/decode register |
| ctrl_bubble | output | 1 | Zero the control bits entering the execute stage |

## Verification
A corrupted stage copy of destination or write-enable shows up as a wrong operand select one or two cycles after the producer leaves decode, when its consumer reaches execute. A wrong load flag shows up in the same cycle as a missing or spurious hold. A bubble that still carries write-enable shows up two cycles after the stall as a write-back select on the held instruction's successor. Sequences are therefore built so that every producer distance, from one to three instructions, is observed on both operands.

// File: rtl/hz_pkg.sv
// Shared types for the bypass and interlock logic.
// Assumes the operand multiplexer in execute decodes these exact codes.
package hz_pkg;

    // Operand source codes for the execute-stage multiplexers
    typedef enum logic [1:0] {
        FWD_REGFILE = 2'b00,
        FWD_MEMWB   = 2'b01,
        FWD_EXMEM   = 2'b10
    } fwd_sel_e;

endpackage

// File: rtl/hz_stage_track.sv
// Carries the hazard fields (sources, destination, write, load) of each
// instruction from decode through execute, memory and write-back.
// Assumes the pipeline advances every cycle except that a bubble replaces
// the decode instruction at the execute boundary.
module hz_stage_track #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bubble,
    input  logic [AW-1:0] dec_rs,
    input  logic [AW-1:0] dec_rt,
    input  logic [AW-1:0] dec_rd,
    input  logic          dec_wr,
    input  logic          dec_ld,
    output logic [AW-1:0] ex_rs,
    output logic [AW-1:0] ex_rt,
    output logic [AW-1:0] ex_rd,
    output logic          ex_wr,
    output logic          ex_ld,
    output logic [AW-1:0] mem_rd,
    output logic          mem_wr,
    output logic          mem_ld,
    output logic [AW-1:0] wb_rd,
    output logic          wb_wr
);

    // Execute-stage copy: take decode fields or a zeroed bubble
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_rs <= '0;
            ex_rt <= '0;
            ex_rd <= '0;
            ex_wr <= 1'b0;
            ex_ld <= 1'b0;
        end else if (bubble) begin
            ex_rs <= '0;
            ex_rt <= '0;
            ex_rd <= '0;
            ex_wr <= 1'b0;
            ex_ld <= 1'b0;
        end else begin
            ex_rs <= dec_rs;
            ex_rt <= dec_rt;
            ex_rd <= dec_rd;
            ex_wr <= dec_wr;
            ex_ld <= dec_ld;
        end
    end

    // Memory-stage copy: always advances from execute
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_rd <= '0;
            mem_wr <= 1'b0;
            mem_ld <= 1'b0;
        end else begin
            mem_rd <= ex_rd;
            mem_wr <= ex_wr;
            mem_ld <= ex_ld;
        end
    end

    // Write-back-stage copy: always advances from memory
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_rd <= '0;
            wb_wr <= 1'b0;
        end else begin
            wb_rd <= mem_rd;
            wb_wr <= mem_wr;
        end
    end

    AST_BUBBLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> (!ex_wr && !ex_ld)); // R8

    AST_MEM_FOLLOWS_EX: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (mem_wr == $past(ex_wr))); // R2

endmodule

// File: rtl/hz_fwd_pick.sv
// Chooses the source of one execute-stage operand by comparing its register
// number against the memory-stage and write-back-stage destinations.
// Assumes register 0 is hard-wired and never a real destination.
module hz_fwd_pick
    import hz_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_wr,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_wr,
    output fwd_sel_e      sel
);

    logic hit_mem;
    logic hit_wb;

    // Match detection against each later stage
    always_comb begin
        hit_mem = mem_wr && (mem_rd != '0) && (mem_rd == src);
        hit_wb  = wb_wr  && (wb_rd  != '0) && (wb_rd  == src);
    end

    // Priority: the newer (memory-stage) result wins
    always_comb begin
        if (hit_mem) begin
            sel = FWD_EXMEM;
        end else if (hit_wb) begin
            sel = FWD_MEMWB;
        end else begin
            sel = FWD_REGFILE;
        end
    end

endmodule

// File: rtl/hz_load_guard.sv
// Detects a load in execute whose destination is read by the decode
// instruction, and requests a one-cycle stall.
// Assumes every decode source is compared, whether or not it is used.
module hz_load_guard #(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic [AW-1:0] dec_src [NSRC],
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_wr,
    input  logic          ex_ld,
    output logic          stall
);

    logic [NSRC-1:0] src_hit;
    logic            ld_live;

    // A load counts only if it really writes a non-zero register
    always_comb begin
        ld_live = ex_ld && ex_wr && (ex_rd != '0);
    end

    // Per-source comparison against the load destination
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        always_comb begin
            src_hit[g] = (dec_src[g] == ex_rd);
        end
    end

    // Stall when any source reads the pending load result
    always_comb begin
        stall = ld_live && (|src_hit);
    end

endmodule

// File: rtl/hz_bypass_interlock.sv
// Top of the data-hazard logic: tracks hazard fields down the pipeline,
// drives the execute operand selects and the load-use stall controls.
// Assumes register-file write-back is visible to a same-cycle read.
module hz_bypass_interlock
    import hz_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] dec_rs,
    input  logic [AW-1:0] dec_rt,
    input  logic [AW-1:0] dec_rd,
    input  logic          dec_wr,
    input  logic          dec_ld,
    output logic [1:0]    fwd_a_sel,
    output logic [1:0]    fwd_b_sel,
    output logic          front_hold,
    output logic          ctrl_bubble
);

    localparam int NSRC = 2;

    logic [AW-1:0] ex_rs;
    logic [AW-1:0] ex_rt;
    logic [AW-1:0] ex_rd;
    logic          ex_wr;
    logic          ex_ld;
    logic [AW-1:0] mem_rd;
    logic          mem_wr;
    logic          mem_ld;
    logic [AW-1:0] wb_rd;
    logic          wb_wr;
    logic          stall;
    logic [AW-1:0] dec_src [NSRC];
    logic [AW-1:0] ex_src  [NSRC];
    fwd_sel_e      sel     [NSRC];

    // Gather per-operand source numbers for decode and execute
    always_comb begin
        dec_src[0] = dec_rs;
        dec_src[1] = dec_rt;
        ex_src[0]  = ex_rs;
        ex_src[1]  = ex_rt;
    end

    hz_stage_track #(.AW(AW)) u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .bubble (stall),
        .dec_rs (dec_rs),
        .dec_rt (dec_rt),
        .dec_rd (dec_rd),
        .dec_wr (dec_wr),
        .dec_ld (dec_ld),
        .ex_rs  (ex_rs),
        .ex_rt  (ex_rt),
        .ex_rd  (ex_rd),
        .ex_wr  (ex_wr),
        .ex_ld  (ex_ld),
        .mem_rd (mem_rd),
        .mem_wr (mem_wr),
        .mem_ld (mem_ld),
        .wb_rd  (wb_rd),
        .wb_wr  (wb_wr)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_op
        hz_fwd_pick #(.AW(AW)) u_pick (
            .src    (ex_src[g]),
            .mem_rd (mem_rd),
            .mem_wr (mem_wr),
            .wb_rd  (wb_rd),
            .wb_wr  (wb_wr),
            .sel    (sel[g])
        );
    end

    hz_load_guard #(.AW(AW), .NSRC(NSRC)) u_guard (
        .dec_src (dec_src),
        .ex_rd   (ex_rd),
        .ex_wr   (ex_wr),
        .ex_ld   (ex_ld),
        .stall   (stall)
    );

    // Drive the block outputs
    always_comb begin
        fwd_a_sel   = sel[0];
        fwd_b_sel   = sel[1];
        front_hold  = stall;
        ctrl_bubble = stall;
    end

    AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        front_hold |=> !front_hold); // R8

    AST_HOLD_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        front_hold |-> (ex_ld && ex_wr)); // R10

    AST_NO_LOAD_FROM_EXMEM: assert property (@(posedge clk) disable iff (!rst_n)
        ((fwd_a_sel == 2'b10) || (fwd_b_sel == 2'b10)) |-> !mem_ld); // R9

    AST_ZERO_NEVER_FWD_A: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a_sel != 2'b00) |-> (ex_rs != '0)); // R5

    AST_ZERO_NEVER_FWD_B: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_b_sel != 2'b00) |-> (ex_rt != '0)); // R5

    AST_PRIORITY_A: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a_sel == 2'b01) |-> !(mem_wr && (mem_rd == ex_rs))); // R4

    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a_sel != 2'b11) && (fwd_b_sel != 2'b11)); // R11

endmodule

// File: tb/hz_bypass_interlock_tb.sv
// Scoreboard bench: the driver presents one decode instruction per cycle and
// queues the outputs expected in that cycle; the monitor compares them.
module hz_bypass_interlock_tb;

    localparam logic [1:0] RF = 2'b00;
    localparam logic [1:0] EM = 2'b10;
    localparam logic [1:0] MW = 2'b01;

    typedef struct {
        logic       hold;
        logic [1:0] a;
        logic [1:0] b;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] dec_rs = '0;
    logic [4:0] dec_rt = '0;
    logic [4:0] dec_rd = '0;
    logic       dec_wr = 1'b0;
    logic       dec_ld = 1'b0;
    logic [1:0] fwd_a_sel;
    logic [1:0] fwd_b_sel;
    logic       front_hold;
    logic       ctrl_bubble;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    hz_bypass_interlock #(.AW(5)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .dec_rs      (dec_rs),
        .dec_rt      (dec_rt),
        .dec_rd      (dec_rd),
        .dec_wr      (dec_wr),
        .dec_ld      (dec_ld),
        .fwd_a_sel   (fwd_a_sel),
        .fwd_b_sel   (fwd_b_sel),
        .front_hold  (front_hold),
        .ctrl_bubble (ctrl_bubble)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Present one decode instruction and queue the expected outputs
    task automatic issue(input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd,
                         input logic wr, input logic ld, input logic h,
                         input logic [1:0] a, input logic [1:0] b, input string tag);
        exp_t e;
        @(negedge clk);
        dec_rs = rs; dec_rt = rt; dec_rd = rd; dec_wr = wr; dec_ld = ld;
        e.hold = h; e.a = a; e.b = b; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Idle cycles without checks to drain the pipeline copy
    task automatic flush();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            dec_rs = '0; dec_rt = '0; dec_rd = '0; dec_wr = 1'b0; dec_ld = 1'b0;
        end
    endtask

    // Monitor: compare away from the active edge
    always @(negedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(e.tag, "front_hold", int'(front_hold), int'(e.hold));
            chk(e.tag, "ctrl_bubble", int'(ctrl_bubble), int'(e.hold));
            chk(e.tag, "fwd_a_sel", int'(fwd_a_sel), int'(e.a));
            chk(e.tag, "fwd_b_sel", int'(fwd_b_sel), int'(e.b));
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: idle state after reset
        issue(0, 0, 0, 0, 0, 0, RF, RF, "R1");
        issue(0, 0, 0, 0, 0, 0, RF, RF, "R1");
        flush();

        // R2, R3, R7: one producer, consumers at distance 1, 2, 3
        issue(2, 3, 1, 1, 0, 0, RF, RF, "R7");
        issue(1, 4, 5, 1, 0, 0, RF, RF, "R7");
        issue(6, 1, 7, 1, 0, 0, EM, RF, "R2");
        issue(1, 8, 9, 1, 0, 0, RF, MW, "R3");
        issue(1, 1, 10, 1, 0, 0, RF, RF, "R7");
        issue(0, 0, 0, 0, 0, 0, RF, RF, "R7");
        flush();

        // R4: both later stages write the same register
        issue(0, 0, 3, 1, 0, 0, RF, RF, "R4");
        issue(0, 0, 3, 1, 0, 0, RF, RF, "R4");
        issue(3, 3, 4, 1, 0, 0, RF, RF, "R4");
        issue(0, 0, 0, 0, 0, 0, EM, EM, "R4");
        flush();

        // R11: operands pick different stages in the same cycle
        issue(0, 0, 11, 1, 0, 0, RF, RF, "R11");
        issue(0, 0, 12, 1, 0, 0, RF, RF, "R11");
        issue(12, 11, 13, 1, 0, 0, RF, RF, "R11");
        issue(0, 0, 0, 0, 0, 0, EM, MW, "R11");
        flush();

        // R5: register 0 as destination, including a load
        issue(0, 0, 0, 1, 0, 0, RF, RF, "R5");
        issue(0, 0, 0, 1, 1, 0, RF, RF, "R5");
        issue(0, 0, 15, 1, 0, 0, RF, RF, "R5");
        issue(0, 0, 0, 0, 0, 0, RF, RF, "R5");
        flush();

        // R6: write-enable low, plain and load
        issue(0, 0, 13, 0, 0, 0, RF, RF, "R6");
        issue(13, 13, 14, 1, 0, 0, RF, RF, "R6");
        issue(0, 0, 16, 0, 1, 0, RF, RF, "R6");
        issue(16, 16, 17, 1, 0, 0, RF, RF, "R6");
        issue(0, 0, 0, 0, 0, 0, RF, RF, "R6");
        flush();

        // R8, R9: load then user on rs
        issue(2, 0, 1, 1, 1, 0, RF, RF, "R8");
        issue(1, 3, 4, 1, 0, 1, RF, RF, "R8");
        issue(1, 3, 4, 1, 0, 0, RF, RF, "R8");
        issue(0, 0, 0, 0, 0, 0, MW, RF, "R9");
        flush();

        // R8, R9: load then user on rt
        issue(0, 0, 5, 1, 1, 0, RF, RF, "R8");
        issue(0, 5, 6, 1, 0, 1, RF, RF, "R8");
        issue(0, 5, 6, 1, 0, 0, RF, RF, "R8");
        issue(0, 0, 0, 0, 0, 0, RF, MW, "R9");
        flush();

        // R10: non-load producer, unrelated load, load two ahead
        issue(0, 0, 6, 1, 0, 0, RF, RF, "R10");
        issue(6, 0, 8, 1, 0, 0, RF, RF, "R10");
        issue(0, 0, 7, 1, 1, 0, EM, RF, "R10");
        issue(8, 9, 10, 1, 0, 0, RF, RF, "R10");
        issue(7, 7, 11, 1, 0, 0, MW, RF, "R10");
        issue(0, 0, 0, 0, 0, 0, MW, MW, "R10");
        flush();

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule